// File: doc/BRIEF.md
# Decode Stage Stall and Skid Controller

This block governs the flow of instructions through one multi-wide decode stage of a single-threaded pipeline. Each cycle fetch may present a group of up to `FW` instructions, oldest in slot 0, and the block forwards up to `DW` of them to the next stage on a registered output group, so results appear one clock after their inputs. Three downstream stages (rename, execute, commit) can each request a stall with a hold pulse and withdraw it with a release pulse. Instructions that cannot be forwarded are parked in a skid buffer. Fetch is told to stop with a one-cycle `fe_stop` pulse and to resume with a one-cycle `fe_go` pulse.

A five-state controller makes every decision. `IDLE` is the reset state and `RUN` is the steady state; both forward fetch groups directly. `BLOCK` is entered on a stall or on a fetch group too wide to forward, either from any other state. `UNBLOCK` is entered from `BLOCK` when every stall clears, and it feeds the output from the skid buffer only. `UNBLOCK` (or `BLOCK`) moves to `RUN` once the skid buffer is empty. `SQUASH` is entered from any state on a commit flush or while commit reports it is still flushing. It moves to `RUN` in the first cycle with neither indication nor a stall. Commit can discard everything in flight with a flush pulse and hold the stage idle with a still-flushing level.

Top module: `decode_flow_ctl`

## Requirements
- R1: After reset the state is `IDLE`, all stall flags are clear, the skid buffer is empty, and `dq_cnt`, `fe_stop`, `fe_go`, `skid_ovf` and `proto_err` are all 0.
- R2: Each downstream stage has a sticky stall flag, set by its hold pulse and cleared by its release pulse. The stage stalls while any flag is set. A release on a clear flag, with no hold in the same cycle, sets the sticky output `proto_err`.
- R3: Decisions follow a fixed priority each cycle: commit flush, then commit still-flushing, then any stall flag (after this cycle's hold and release pulses), then leaving `BLOCK`/`UNBLOCK`, then normal forwarding.
- R4: A commit flush discards the fetch group, the skid buffer and any pending output, and enters `SQUASH`. The next cycle shows `dq_cnt`=0. It raises `fe_go` only if the state was `BLOCK` or `UNBLOCK`.
- R5: While the still-flushing level is high the state stays `SQUASH` and arriving groups are dropped. With no flush, no flushing level and no stall, `SQUASH` becomes `RUN` and forwards that same cycle's group.
- R6: While stalled, no instruction is forwarded and arriving groups are appended to the skid buffer. `fe_stop` pulses once on entering `BLOCK` and does not repeat while the state stays `BLOCK`.
- R7: In `UNBLOCK`, up to `DW` instructions are forwarded from the skid buffer only, oldest first, and the group arriving in that cycle is appended behind them.
- R8: `fe_go` pulses, and the state returns to `RUN`, only in the cycle the skid buffer becomes empty.
- R9: In `IDLE`, `RUN` or after leaving `SQUASH`, up to `DW` instructions of the group are forwarded, slot 0 first. Any remainder goes to the skid buffer and the state enters `BLOCK` with one `fe_stop` pulse.
- R10: Skid capacity is `LAT*FW + DW` entries. An append that exceeds the capacity sets the sticky `skid_ovf`, keeps every stored entry and drops only the entries that do not fit.
- R11: Forwarded instructions appear one clock after the deciding edge, in exactly the order fetch presented them, excluding instructions discarded by a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_cnt | input | $clog2(FW+1) | Number of valid instructions in the fetch group (0 = none) |
| fe_items | input | FW*IW | Fetch group; slot i at bits [i*IW +: IW], slot 0 oldest |
| rn_hold | input | 1 | Rename stall request pulse |
| rn_rel | input | 1 | Rename stall withdrawal pulse |
| ex_hold | input | 1 | Execute stall request pulse |
| ex_rel | input | 1 | Execute stall withdrawal pulse |
| cm_hold | input | 1 | Commit stall request pulse |
| cm_rel | input | 1 | Commit stall withdrawal pulse |
| cm_flush | input | 1 | Commit flush pulse |
| cm_flushing | input | 1 | Commit still-flushing level |
| dq_cnt | output | $clog2(DW+1) | Number of valid instructions in the output group |
| dq_items | output | DW*IW | Output group; slot i at bits [i*IW +: IW], slot 0 oldest |
| fe_stop | output | 1 | One-cycle request to fetch to stop |
| fe_go | output | 1 | One-cycle permission to fetch to resume |
| skid_ovf | output | 1 | Sticky skid buffer overflow flag |
| proto_err | output | 1 | Sticky release-without-hold flag |

## Verification
The bench targets the following corner cases:
- A group wider than the output, where a design that forwarded from fetch while the skid held older entries would reorder instructions.
- Arrivals during `UNBLOCK`, where the same reordering could occur.
- Two stages stalling and one releasing, where a design that cleared on the first release would forward too early.
- A flush while blocked, where a missing `fe_go` would leave fetch stopped for good.
- A flush while running, where a spurious `fe_go` would appear.
- The still-flushing level coinciding with a release, where a wrong priority would forward dropped instructions.
- The first group after `SQUASH`, which must pass in the same cycle.
- An overflow, after which the drained order shows whether old or new entries were lost.

// File: rtl/decode_flow_pkg.sv
package decode_flow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_BLOCK,
        ST_UNBLOCK,
        ST_SQUASH
    } dstate_t;

endpackage

// File: rtl/decode_stall_track.sv
// Sticky per-stage stall flags with release-without-hold detection.
module decode_stall_track #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hold,
    input  logic [NSRC-1:0] rel,
    output logic            stalled,
    output logic            proto_err
);

    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] flag_d;
    logic [NSRC-1:0] bad;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign flag_d[s] = (flag_q[s] | hold[s]) & ~rel[s];
        assign bad[s]    = rel[s] & ~flag_q[s] & ~hold[s];
    end

    assign stalled = |flag_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q    <= '0;
            proto_err <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (|bad) proto_err <= 1'b1;
        end
    end

endmodule

// File: rtl/decode_skid_buf.sv
// Circular skid buffer: up to DW pops then up to FW pushes per cycle.
module decode_skid_buf #(
    parameter int IW    = 8,
    parameter int FW    = 3,
    parameter int DW    = 2,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(FW + 1),
    localparam int OCW  = $clog2(DW + 1),
    localparam int SCW  = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [OCW-1:0]   pop_n,
    input  logic [CW-1:0]    push_n,
    input  logic [FW*IW-1:0] push_items,
    output logic [SCW-1:0]   count,
    output logic [DW*IW-1:0] head_items,
    output logic             ovf
);

    logic [IW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_q;
    logic [SCW-1:0] cnt_q;
    int            fit;
    int            space;

    function automatic logic [PW-1:0] wrap(input int v);
        return PW'(v % DEPTH);
    endfunction

    assign count = cnt_q;

    for (genvar h = 0; h < DW; h++) begin : g_head
        assign head_items[h*IW +: IW] = mem[wrap(int'(rd_q) + h)];
    end

    always_comb begin
        space = DEPTH - int'(cnt_q) + int'(pop_n);
        ovf   = int'(push_n) > space;
        fit   = ovf ? space : int'(push_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            rd_q  <= wrap(int'(rd_q) + int'(pop_n));
            cnt_q <= SCW'(int'(cnt_q) - int'(pop_n) + fit);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < FW; i++) begin
            if (rst_n && !flush && i < fit)
                mem[wrap(int'(rd_q) + int'(cnt_q) + i)] <= push_items[i*IW +: IW];
        end
    end

endmodule

// File: rtl/decode_flow_ctl.sv
module decode_flow_ctl
    import decode_flow_pkg::*;
#(
    parameter int IW   = 8,
    parameter int FW   = 3,
    parameter int DW   = 2,
    parameter int LAT  = 2,
    localparam int DEPTH = LAT * FW + DW,
    localparam int CW    = $clog2(FW + 1),
    localparam int OCW   = $clog2(DW + 1),
    localparam int SCW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    fe_cnt,
    input  logic [FW*IW-1:0] fe_items,
    input  logic             rn_hold,
    input  logic             rn_rel,
    input  logic             ex_hold,
    input  logic             ex_rel,
    input  logic             cm_hold,
    input  logic             cm_rel,
    input  logic             cm_flush,
    input  logic             cm_flushing,
    output logic [OCW-1:0]   dq_cnt,
    output logic [DW*IW-1:0] dq_items,
    output logic             fe_stop,
    output logic             fe_go,
    output logic             skid_ovf,
    output logic             proto_err
);

    dstate_t state_q, state_d;
    logic             stalled;
    logic [SCW-1:0]   skid_cnt;
    logic [DW*IW-1:0] head_items;
    logic [FW*IW-1:0] push_items;
    logic [DW*IW-1:0] out_items;
    logic             ovf_now;
    logic             flush;
    logic             from_skid;
    logic             stop_p;
    logic             go_p;
    int               in_n, skid_n, send_n, pop_n, push_n, push_off;
    logic [IW-1:0]    fe_arr [FW];

    for (genvar f = 0; f < FW; f++) begin : g_fe
        assign fe_arr[f] = fe_items[f*IW +: IW];
    end

    decode_stall_track #(.NSRC(3)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      ({cm_hold, ex_hold, rn_hold}),
        .rel       ({cm_rel, ex_rel, rn_rel}),
        .stalled   (stalled),
        .proto_err (proto_err)
    );

    decode_skid_buf #(.IW(IW), .FW(FW), .DW(DW), .DEPTH(DEPTH)) u_skid (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .pop_n      (OCW'(pop_n)),
        .push_n     (CW'(push_n)),
        .push_items (push_items),
        .count      (skid_cnt),
        .head_items (head_items),
        .ovf        (ovf_now)
    );

    assign in_n   = (int'(fe_cnt) > FW) ? FW : int'(fe_cnt);
    assign skid_n = int'(skid_cnt);

    // Next-state and per-cycle action decode, in priority order.
    always_comb begin
        state_d   = state_q;
        flush     = 1'b0;
        from_skid = 1'b0;
        send_n    = 0;
        pop_n     = 0;
        push_n    = 0;
        push_off  = 0;
        stop_p    = 1'b0;
        go_p      = 1'b0;
        if (cm_flush) begin
            flush   = 1'b1;
            state_d = ST_SQUASH;
            go_p    = (state_q == ST_BLOCK) || (state_q == ST_UNBLOCK);
        end else if (cm_flushing) begin
            flush   = 1'b1;
            state_d = ST_SQUASH;
        end else if (stalled) begin
            push_n = in_n;
            if (state_q != ST_BLOCK) begin
                state_d = ST_BLOCK;
                stop_p  = 1'b1;
            end
        end else begin
            unique case (state_q)
                ST_BLOCK, ST_UNBLOCK: begin
                    from_skid = 1'b1;
                    send_n    = (skid_n < DW) ? skid_n : DW;
                    pop_n     = send_n;
                    push_n    = in_n;
                    if (skid_n - send_n + in_n == 0) begin
                        state_d = ST_RUN;
                        go_p    = 1'b1;
                    end else begin
                        state_d = ST_UNBLOCK;
                    end
                end
                ST_IDLE, ST_RUN, ST_SQUASH: begin
                    if (state_q == ST_SQUASH) state_d = ST_RUN;
                    send_n = (in_n < DW) ? in_n : DW;
                    if (in_n > send_n) begin
                        push_n   = in_n - send_n;
                        push_off = send_n;
                        state_d  = ST_BLOCK;
                        stop_p   = 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        push_items = '0;
        for (int i = 0; i < FW; i++) begin
            if (i + push_off < FW) push_items[i*IW +: IW] = fe_arr[i + push_off];
        end
        out_items = '0;
        for (int i = 0; i < DW; i++) begin
            if (i < send_n) begin
                if (from_skid)   out_items[i*IW +: IW] = head_items[i*IW +: IW];
                else if (i < FW) out_items[i*IW +: IW] = fe_arr[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_cnt   <= '0;
            dq_items <= '0;
            fe_stop  <= 1'b0;
            fe_go    <= 1'b0;
            skid_ovf <= 1'b0;
        end else begin
            dq_cnt   <= OCW'(send_n);
            dq_items <= out_items;
            fe_stop  <= stop_p;
            fe_go    <= go_p;
            if (ovf_now) skid_ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/decode_flow_chk.sv
module decode_flow_chk
    import decode_flow_pkg::*;
#(
    parameter int DW    = 2,
    parameter int DEPTH = 8,
    localparam int OCW  = $clog2(DW + 1),
    localparam int SCW  = $clog2(DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cm_flush,
    input logic [OCW-1:0] dq_cnt,
    input logic           fe_stop,
    input logic           fe_go,
    input logic           skid_ovf,
    input dstate_t        state_q,
    input logic [SCW-1:0] skid_n
);

    // R4: a flush yields an empty output group and the squashing state
    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cm_flush |=> (dq_cnt == '0 && state_q == ST_SQUASH));

    // R6: no back-to-back stop pulses
    assert_stop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fe_stop |=> !fe_stop);

    // R8: stop and go never coincide
    assert_stop_go_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fe_stop && fe_go));

    // R9: direct forwarding states never hold parked instructions
    assert_run_skid_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN || state_q == ST_IDLE) |-> skid_n == '0);

    // R10: occupancy bound and sticky overflow
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(skid_n) <= DEPTH);
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        skid_ovf |=> skid_ovf);

    // R11: output width bound
    assert_out_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dq_cnt) <= DW);

endmodule

bind decode_flow_ctl decode_flow_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cm_flush (cm_flush),
    .dq_cnt   (dq_cnt),
    .fe_stop  (fe_stop),
    .fe_go    (fe_go),
    .skid_ovf (skid_ovf),
    .state_q  (state_q),
    .skid_n   (skid_cnt)
);

// File: tb/test_decode_flow_ctl.sv
module test_decode_flow_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int IW = 8;
    localparam int FW = 3;
    localparam int DW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]      fe_cnt = '0;
    logic [FW*IW-1:0] fe_items = '0;
    logic rn_hold = 0, rn_rel = 0, ex_hold = 0, ex_rel = 0, cm_hold = 0, cm_rel = 0;
    logic cm_flush = 0, cm_flushing = 0;
    logic [1:0]       dq_cnt;
    logic [DW*IW-1:0] dq_items;
    logic fe_stop, fe_go, skid_ovf, proto_err;

    int total = 0, bad = 0, stop_cnt = 0, go_cnt = 0, out_total = 0;
    bit done = 0;
    logic [IW-1:0] serial = 8'd1;
    logic [IW-1:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    decode_flow_ctl #(.IW(IW), .FW(FW), .DW(DW), .LAT(2)) i_decode_flow_ctl (
        .clk(clk), .rst_n(rst_n), .fe_cnt(fe_cnt), .fe_items(fe_items),
        .rn_hold(rn_hold), .rn_rel(rn_rel), .ex_hold(ex_hold), .ex_rel(ex_rel),
        .cm_hold(cm_hold), .cm_rel(cm_rel), .cm_flush(cm_flush), .cm_flushing(cm_flushing),
        .dq_cnt(dq_cnt), .dq_items(dq_items), .fe_stop(fe_stop), .fe_go(fe_go),
        .skid_ovf(skid_ovf), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: sample between edges
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (fe_stop) stop_cnt++;
            if (fe_go)   go_cnt++;
            for (int i = 0; i < int'(dq_cnt); i++) begin
                out_total++;
                if (exp_q.size() == 0) begin
                    chk(0, "R11 unexpected output", int'(dq_items[i*IW +: IW]), -1);
                end else begin
                    logic [IW-1:0] e;
                    e = exp_q.pop_front();
                    chk(dq_items[i*IW +: IW] == e, "R11 order", int'(dq_items[i*IW +: IW]), int'(e));
                end
            end
        end
    end

    // Driver: present a group of n items, the first nkeep of which must come out
    task automatic drive(input int n, input int nkeep);
        fe_cnt = 2'(n);
        fe_items = '0;
        for (int i = 0; i < n; i++) begin
            fe_items[i*IW +: IW] = serial;
            if (i < nkeep) exp_q.push_back(serial);
            serial = serial + 8'd1;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        fe_cnt = '0; fe_items = '0;
        rn_hold = 0; rn_rel = 0; ex_hold = 0; ex_rel = 0; cm_hold = 0; cm_rel = 0;
        cm_flush = 0; cm_flushing = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int s0, g0, o0;
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        chk(dq_cnt == 0 && !fe_stop && !fe_go, "R1 outputs after reset", int'(dq_cnt), 0);
        chk(!skid_ovf && !proto_err, "R1 sticky flags after reset", int'(skid_ovf) + int'(proto_err), 0);
        idle(1);

        // R9/R11: two-wide group passes next cycle with no stop
        drive(2, 2); step();
        chk(dq_cnt == 2, "R11 latency one cycle", int'(dq_cnt), 2);
        chk(!fe_stop, "R9 no stop when group fits", int'(fe_stop), 0);
        idle(2);

        // R9/R8: three-wide group blocks, then drains and resumes
        s0 = stop_cnt; g0 = go_cnt;
        drive(3, 3); step();
        chk(dq_cnt == 2 && fe_stop, "R9 leftover blocks", int'(fe_stop), 1);
        step();
        chk(dq_cnt == 1 && fe_go, "R8 go when skid empties", int'(fe_go), 1);
        idle(3);
        chk(stop_cnt - s0 == 1 && go_cnt - g0 == 1, "R9 one stop one go", stop_cnt - s0, 1);

        // R6/R7/R8: stall, arrivals parked, unblock with arrivals
        s0 = stop_cnt; g0 = go_cnt; o0 = out_total;
        rn_hold = 1; drive(3, 3); step();
        drive(3, 3); step();
        step();
        chk(out_total == o0, "R6 nothing forwarded while stalled", out_total - o0, 0);
        chk(stop_cnt - s0 == 1, "R6 single stop pulse", stop_cnt - s0, 1);
        rn_rel = 1; step();
        chk(dq_cnt == 2 && !fe_go, "R7 drain begins from skid", int'(dq_cnt), 2);
        drive(3, 3); step();
        idle(6);
        chk(go_cnt - g0 == 1, "R8 single go after drain", go_cnt - g0, 1);
        chk(exp_q.size() == 0, "R7 all parked items forwarded", exp_q.size(), 0);

        // R2: two stages stalled, one released
        s0 = stop_cnt; o0 = out_total;
        ex_hold = 1; cm_hold = 1; drive(3, 3); step();
        ex_rel = 1; drive(2, 2); step();
        step();
        chk(out_total == o0, "R2 remaining flag still stalls", out_total - o0, 0);
        cm_rel = 1; step();
        chk(dq_cnt == 2, "R2 release of last flag resumes", int'(dq_cnt), 2);
        idle(5);
        chk(!proto_err, "R2 legal releases no error", int'(proto_err), 0);
        chk(exp_q.size() == 0, "R2 stalled items forwarded", exp_q.size(), 0);

        // R4/R5/R3: flush while blocked
        g0 = go_cnt;
        rn_hold = 1; drive(3, 0); step();
        cm_flush = 1; step();
        chk(fe_go && dq_cnt == 0, "R4 go on flush from blocked", int'(fe_go), 1);
        cm_flushing = 1; rn_rel = 1; drive(3, 0); step();
        chk(dq_cnt == 0 && !fe_go, "R3 flushing outranks release", int'(dq_cnt), 0);
        drive(2, 2); step();
        chk(dq_cnt == 2, "R5 squash to run same cycle", int'(dq_cnt), 2);
        idle(2);

        // R4: flush while running gives no go
        g0 = go_cnt;
        drive(2, 2); step();
        cm_flush = 1; drive(3, 0); step();
        chk(!fe_go && dq_cnt == 0, "R4 no go on flush from run", int'(fe_go), 0);
        idle(3);
        chk(go_cnt == g0, "R4 no go afterwards", go_cnt - g0, 0);

        // R3: stall outranks forwarding of oversized group without double stop
        s0 = stop_cnt;
        rn_hold = 1; drive(3, 3); step();
        chk(dq_cnt == 0 && fe_stop, "R3 stall outranks forwarding", int'(dq_cnt), 0);
        rn_rel = 1; step();
        idle(4);
        chk(stop_cnt - s0 == 1 && exp_q.size() == 0, "R6 stall drained", stop_cnt - s0, 1);

        // R10: overflow keeps stored entries, drops excess
        rn_hold = 1; drive(3, 3); step();
        drive(3, 3); step();
        chk(!skid_ovf, "R10 full to six no overflow", int'(skid_ovf), 0);
        drive(3, 2); step();
        chk(skid_ovf, "R10 overflow flagged", int'(skid_ovf), 1);
        rn_rel = 1; step();
        idle(6);
        chk(exp_q.size() == 0, "R10 eight stored items drained", exp_q.size(), 0);
        chk(skid_ovf, "R10 overflow sticky", int'(skid_ovf), 1);

        // R2: release without hold
        ex_rel = 1; step();
        chk(proto_err, "R2 release on clear flag", int'(proto_err), 1);
        idle(2);
        chk(exp_q.size() == 0, "R11 scoreboard empty", exp_q.size(), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule